// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit performs the shift and rotate operations of a 64-bit RISC core that also executes 32-bit operations. Each request carries a decoded operation selector, the instruction word, a 64-bit source operand, an 8-bit immediate amount and a 64-bit register amount. The operations are logical left, logical right, arithmetic right and rotate right. Each comes in a word form that works on the low half and sign-extends the result, and a doubleword form. The doubleword immediate family also has variants that add 32 to the amount.

Logical right and rotate right share one selector value per family. A 5-bit field of the instruction picks between them, and any other field value is reported as a reserved instruction. The result and the reserved flag come out of a register one cycle after the request. A reserved result is forced to zero so that nothing stale can be written back.

Top module: `shift_rotate_unit`

## Requirements
- R1: While reset is held, and after reset before any request, out_valid, rsvd_instr and result are all 0.
- R2: out_valid rises exactly one cycle after in_valid. When out_valid is 0, result and rsvd_instr are 0.
- R3: Immediate forms use only bits 4:0 of imm_amt. Bits 7:5 have no effect on the result.
- R4: Register-amount forms use amt_reg bits 4:0 for word operations and amt_reg bits 5:0 for doubleword operations.
- R5: Word operations (op_sel 0 to 5) work on src[31:0]. Their 32-bit result is sign-extended from bit 31 into result[63:32]. Word arithmetic right fills the vacated bits with src[31].
- R6: For op_sel 2, 8 and 11 (immediate right-logical), instr[25:21] selects the operation: 0 is logical right, 1 is rotate right, and any other value is reserved.
- R7: For op_sel 5 and 14 (register-amount right-logical), instr[10:6] selects the operation in the same way: 0 is logical, 1 is rotate, and any other value is reserved.
- R8: A rotate by zero returns the operand unchanged. For the word form this is src[31:0] sign-extended, and for the doubleword form it is src.
- R9: Rotate right by n returns the bits shifted out at the low end back in at the high end, over 32 bits for word forms and over 64 bits for doubleword forms.
- R10: op_sel 9, 10 and 11 (left logical, right arithmetic, right logical or rotate) shift by 32 plus imm_amt[4:0], which gives an amount from 32 to 63.
- R11: When rsvd_instr is 1, result is 0.
- R12: op_sel 15 is always reserved. With ALLOW_WIDE = 0, every doubleword operation (op_sel 6 to 14) is reserved as well.
- R13: Doubleword logical and arithmetic shifts (op_sel 6, 7, 8, 12, 13, 14) act on all 64 bits. Arithmetic right fills the vacated bits with src[63].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 4 | Selector: 0 SLL, 1 SRA, 2 SRL, 3 SLLV, 4 SRAV, 5 SRLV, 6 DSLL, 7 DSRA, 8 DSRL, 9 DSLL32, 10 DSRA32, 11 DSRL32, 12 DSLLV, 13 DSRAV, 14 DSRLV, 15 none |
| instr | input | 32 | Instruction word that carries the right-logical select fields |
| imm_amt | input | 8 | Immediate amount; only the low 5 bits are used |
| amt_reg | input | 64 | Register-supplied amount |
| src | input | 64 | Source operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 64 | Registered result |
| rsvd_instr | output | 1 | Reserved-instruction flag |

## Verification
The bench builds two copies of the unit and drives them with the same stimulus: one with the default ALLOW_WIDE = 1 and one with ALLOW_WIDE = 0. The first copy covers every doubleword form, the plus-32 amounts, 64-bit rotates and the select-field decoding. The second copy reaches the rule that doubleword forms are reserved on a 32-bit-only configuration, while its word forms must still give the same results as the first copy. A behavioural model compares both copies on every clock, under directed corner cases and a long run of random requests.

// File: rtl/shrot_pkg.sv
`timescale 1ns/1ps
package shrot_pkg;
    typedef enum logic [3:0] {
        OP_SLL    = 4'd0,
        OP_SRA    = 4'd1,
        OP_SRL    = 4'd2,
        OP_SLLV   = 4'd3,
        OP_SRAV   = 4'd4,
        OP_SRLV   = 4'd5,
        OP_DSLL   = 4'd6,
        OP_DSRA   = 4'd7,
        OP_DSRL   = 4'd8,
        OP_DSLL32 = 4'd9,
        OP_DSRA32 = 4'd10,
        OP_DSRL32 = 4'd11,
        OP_DSLLV  = 4'd12,
        OP_DSRAV  = 4'd13,
        OP_DSRLV  = 4'd14,
        OP_NONE   = 4'd15
    } shift_op_e;

    typedef enum logic [1:0] {
        K_LL = 2'd0,
        K_RA = 2'd1,
        K_RL = 2'd2,
        K_RR = 2'd3
    } shift_kind_e;

    localparam int IMM_SEL_LO = 21;
    localparam int REG_SEL_LO = 6;
    localparam int SEL_W      = 5;
endpackage

// File: rtl/shrot_decode.sv
`timescale 1ns/1ps
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter bit ALLOW_WIDE = 1'b1
) (
    input  logic [3:0]              op_sel,
    input  logic [31:0]             instr,
    input  logic [7:0]              imm_amt,
    input  logic [DATA_W-1:0]       amt_reg,
    output shift_kind_e             kind,
    output logic                    word,
    output logic [$clog2(DATA_W)-1:0] amt,
    output logic                    rsvd
);
    localparam int AMT_W = $clog2(DATA_W);
    localparam int IMM_W = AMT_W - 1;

    logic [SEL_W-1:0] sel_imm, sel_reg, rl_sel;
    logic [IMM_W-1:0] imm_n, reg_w;
    logic [AMT_W-1:0] reg_d;
    logic             rl_chk, is_wide;

    always_comb begin
        sel_imm = instr[IMM_SEL_LO +: SEL_W];
        sel_reg = instr[REG_SEL_LO +: SEL_W];
        imm_n   = imm_amt[IMM_W-1:0];
        reg_w   = amt_reg[IMM_W-1:0];
        reg_d   = amt_reg[AMT_W-1:0];
        kind    = K_LL;
        word    = 1'b1;
        amt     = '0;
        rsvd    = 1'b0;
        is_wide = 1'b0;
        rl_chk  = 1'b0;
        rl_sel  = '0;
        case (shift_op_e'(op_sel))
            OP_SLL:    begin kind = K_LL; amt = {1'b0, imm_n}; end
            OP_SRA:    begin kind = K_RA; amt = {1'b0, imm_n}; end
            OP_SRL:    begin amt = {1'b0, imm_n}; rl_chk = 1'b1; rl_sel = sel_imm; end
            OP_SLLV:   begin kind = K_LL; amt = {1'b0, reg_w}; end
            OP_SRAV:   begin kind = K_RA; amt = {1'b0, reg_w}; end
            OP_SRLV:   begin amt = {1'b0, reg_w}; rl_chk = 1'b1; rl_sel = sel_reg; end
            OP_DSLL:   begin kind = K_LL; word = 1'b0; is_wide = 1'b1; amt = {1'b0, imm_n}; end
            OP_DSRA:   begin kind = K_RA; word = 1'b0; is_wide = 1'b1; amt = {1'b0, imm_n}; end
            OP_DSRL:   begin word = 1'b0; is_wide = 1'b1; amt = {1'b0, imm_n};
                             rl_chk = 1'b1; rl_sel = sel_imm; end
            OP_DSLL32: begin kind = K_LL; word = 1'b0; is_wide = 1'b1; amt = {1'b1, imm_n}; end
            OP_DSRA32: begin kind = K_RA; word = 1'b0; is_wide = 1'b1; amt = {1'b1, imm_n}; end
            OP_DSRL32: begin word = 1'b0; is_wide = 1'b1; amt = {1'b1, imm_n};
                             rl_chk = 1'b1; rl_sel = sel_imm; end
            OP_DSLLV:  begin kind = K_LL; word = 1'b0; is_wide = 1'b1; amt = reg_d; end
            OP_DSRAV:  begin kind = K_RA; word = 1'b0; is_wide = 1'b1; amt = reg_d; end
            OP_DSRLV:  begin word = 1'b0; is_wide = 1'b1; amt = reg_d;
                             rl_chk = 1'b1; rl_sel = sel_reg; end
            default:   rsvd = 1'b1;
        endcase
        if (rl_chk) begin
            case (rl_sel)
                SEL_W'(0): kind = K_RL;
                SEL_W'(1): kind = K_RR;
                default:   rsvd = 1'b1;
            endcase
        end
        if (is_wide && !ALLOW_WIDE) begin
            rsvd = 1'b1;
        end
    end

    always_comb begin
        // R12
        if (!ALLOW_WIDE && !rsvd) begin
            wide_block_chk: assert (word)
                else $error("doubleword form accepted on a 32-bit-only unit");
        end
    end
endmodule

// File: rtl/shrot_lane.sv
`timescale 1ns/1ps
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    input  shift_kind_e          kind,
    output logic [W-1:0]         dout
);
    localparam int N_W = $clog2(W);

    logic [N_W:0]   back;
    logic [W-1:0]   rot;

    always_comb begin
        back = (N_W+1)'(W) - {1'b0, amt};
        rot  = (amt == '0) ? din : ((din >> amt) | (din << back));
        case (kind)
            K_LL:    dout = din << amt;
            K_RA:    dout = $unsigned($signed(din) >>> amt);
            K_RL:    dout = din >> amt;
            default: dout = rot;
        endcase
    end

    always_comb begin
        // R8
        if (kind == K_RR && amt == '0) begin
            rot_zero_pass_chk: assert (dout == din)
                else $error("rotate by zero altered the operand");
        end
    end
endmodule

// File: rtl/shrot_core.sv
`timescale 1ns/1ps
module shrot_core
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]         opnd,
    input  logic [$clog2(DATA_W)-1:0] amt,
    input  shift_kind_e               kind,
    input  logic                      word,
    output logic [DATA_W-1:0]         res
);
    localparam int HALF_W = DATA_W / 2;
    localparam int AMT_W  = $clog2(DATA_W);
    localparam int HAMT_W = AMT_W - 1;

    logic [HALF_W-1:0] w_res;
    logic [DATA_W-1:0] d_res;

    shrot_lane #(.W(HALF_W)) i_word_lane (
        .din  (opnd[HALF_W-1:0]),
        .amt  (amt[HAMT_W-1:0]),
        .kind (kind),
        .dout (w_res)
    );

    shrot_lane #(.W(DATA_W)) i_dbl_lane (
        .din  (opnd),
        .amt  (amt),
        .kind (kind),
        .dout (d_res)
    );

    always_comb begin
        res = word ? {{HALF_W{w_res[HALF_W-1]}}, w_res} : d_res;
    end
endmodule

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
module shift_rotate_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter bit ALLOW_WIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_sel,
    input  logic [31:0]       instr,
    input  logic [7:0]        imm_amt,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [DATA_W-1:0] src,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              rsvd_instr
);
    localparam int AMT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              vld;
        logic              rsvd;
        logic [DATA_W-1:0] res;
    } out_st_t;

    out_st_t           st_d, st_q;
    shift_kind_e       dec_kind;
    logic              dec_word, dec_rsvd;
    logic [AMT_W-1:0]  dec_amt;
    logic [DATA_W-1:0] core_res;

    shrot_decode #(.DATA_W(DATA_W), .ALLOW_WIDE(ALLOW_WIDE)) i_decode (
        .op_sel  (op_sel),
        .instr   (instr),
        .imm_amt (imm_amt),
        .amt_reg (amt_reg),
        .kind    (dec_kind),
        .word    (dec_word),
        .amt     (dec_amt),
        .rsvd    (dec_rsvd)
    );

    shrot_core #(.DATA_W(DATA_W)) i_core (
        .opnd (src),
        .amt  (dec_amt),
        .kind (dec_kind),
        .word (dec_word),
        .res  (core_res)
    );

    always_comb begin
        st_d      = '0;
        st_d.vld  = in_valid;
        st_d.rsvd = in_valid && dec_rsvd;
        if (in_valid && !dec_rsvd) begin
            st_d.res = core_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign rsvd_instr = st_q.rsvd;
    assign result     = st_q.res;

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("result strobe missing one cycle after request");

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (result == '0 && !rsvd_instr))
        else $error("outputs active without a result strobe");

    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_instr |-> (out_valid && result == '0))
        else $error("reserved result not cleared");
endmodule

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] instr = '0;
    logic [7:0]  imm_amt = '0;
    logic [63:0] amt_reg = '0;
    logic [63:0] src = '0;
    logic        ov_w, rs_w, ov_n, rs_n;
    logic [63:0] res_w, res_n;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R2";

    always #2.5 clk = ~clk;

    shift_rotate_unit #(.DATA_W(64), .ALLOW_WIDE(1'b1)) i_shift_rotate_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .instr(instr), .imm_amt(imm_amt), .amt_reg(amt_reg), .src(src),
        .out_valid(ov_w), .result(res_w), .rsvd_instr(rs_w));

    shift_rotate_unit #(.DATA_W(64), .ALLOW_WIDE(1'b0)) i_shift_rotate_unit_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .instr(instr), .imm_amt(imm_amt), .amt_reg(amt_reg), .src(src),
        .out_valid(ov_n), .result(res_n), .rsvd_instr(rs_n));

    // Behavioural reference: returns {reserved, result}
    function automatic logic [64:0] ref_calc(int op, logic [31:0] ins, logic [7:0] imm,
                                             logic [63:0] ra, logic [63:0] s, bit wide_ok);
        int          n, k, sel;
        bit          isword;
        logic [31:0] w;
        logic [63:0] tw;
        logic [127:0] td;
        logic [63:0] r;
        isword = (op <= 5);
        if (op == 15) return {1'b1, 64'd0};
        if (!isword && !wide_ok) return {1'b1, 64'd0};
        if (op == 3 || op == 4 || op == 5) n = int'(ra % 32);
        else if (op >= 12) n = int'(ra % 64);
        else if (op >= 9) n = 32 + int'(imm % 32);
        else n = int'(imm % 32);
        k = op % 3;
        if (k == 2) begin
            sel = (op == 5 || op == 14) ? int'(ins[10:6]) : int'(ins[25:21]);
            if (sel == 1) k = 3;
            else if (sel != 0) return {1'b1, 64'd0};
        end
        if (isword) begin
            w = s[31:0];
            case (k)
                0: w = w << n;
                1: w = $unsigned($signed(w) >>> n);
                2: w = w >> n;
                default: begin tw = {w, w} >> n; w = tw[31:0]; end
            endcase
            r = {{32{w[31]}}, w};
        end else begin
            case (k)
                0: r = s << n;
                1: r = $unsigned($signed(s) >>> n);
                2: r = s >> n;
                default: begin td = {s, s} >> n; r = td[63:0]; end
            endcase
        end
        return {1'b0, r};
    endfunction

    logic        ev_w, er_w, ev_n, er_n;
    logic [63:0] ex_w, ex_n;
    string       exp_tag, exp_tag_n;

    always @(posedge clk or negedge rst_n) begin
        logic [64:0] t;
        if (!rst_n) begin
            ev_w <= 0; er_w <= 0; ex_w <= '0;
            ev_n <= 0; er_n <= 0; ex_n <= '0;
            exp_tag <= "R1"; exp_tag_n <= "R1";
        end else begin
            ev_w <= in_valid; ev_n <= in_valid;
            exp_tag <= cur_tag;
            exp_tag_n <= (in_valid && op_sel >= 4'd6) ? "R12" : cur_tag;
            if (in_valid) begin
                t = ref_calc(int'(op_sel), instr, imm_amt, amt_reg, src, 1'b1);
                er_w <= t[64]; ex_w <= t[63:0];
                t = ref_calc(int'(op_sel), instr, imm_amt, amt_reg, src, 1'b0);
                er_n <= t[64]; ex_n <= t[63:0];
            end else begin
                er_w <= 0; ex_w <= '0; er_n <= 0; ex_n <= '0;
            end
        end
    end

    task automatic cmp(string tag, string who, logic av, logic ar, logic [63:0] ad,
                       logic xv, logic xr, logic [63:0] xd);
        checks++;
        if (av !== xv || ar !== xr || ad !== xd) begin
            errors++;
            $display("FAIL %s %s actual v=%0b r=%0b d=%h expected v=%0b r=%0b d=%h",
                     tag, who, av, ar, ad, xv, xr, xd);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        cmp(exp_tag, "wide", ov_w, rs_w, res_w, ev_w, er_w, ex_w);
        cmp(exp_tag_n, "narrow", ov_n, rs_n, res_n, ev_n, er_n, ex_n);
    end

    task automatic issue(logic [3:0] op, logic [31:0] ins, logic [7:0] imm,
                         logic [63:0] ra, logic [63:0] s, string tag);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; instr = ins; imm_amt = imm;
        amt_reg = ra; src = s; cur_tag = tag;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; cur_tag = "R2";
        end
    endtask

    function automatic logic [31:0] sel_hi(int v);
        return 32'(v) << 21;
    endfunction

    function automatic logic [31:0] sel_lo(int v);
        return 32'(v) << 6;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] a = 64'hF123_4567_8000_0010;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R3: upper immediate bits ignored
        issue(4'd0, '0, 8'hE4, '0, a, "R3");
        issue(4'd0, '0, 8'h04, '0, a, "R3");
        // R5: word arithmetic right with bit 31 set
        issue(4'd1, '0, 8'd4, '0, a, "R5");
        issue(4'd0, '0, 8'd31, '0, 64'h1, "R5");
        // R6: immediate select field
        issue(4'd2, sel_hi(0), 8'd8, '0, a, "R6");
        issue(4'd2, sel_hi(1), 8'd8, '0, a, "R9");
        issue(4'd2, sel_hi(2), 8'd8, '0, a, "R6");
        issue(4'd2, sel_hi(31), 8'd8, '0, a, "R11");
        issue(4'd8, sel_hi(3), 8'd8, '0, a, "R6");
        // R8: rotate by zero
        issue(4'd2, sel_hi(1), 8'd0, '0, a, "R8");
        issue(4'd8, sel_hi(1), 8'd0, '0, a, "R8");
        issue(4'd14, sel_lo(1), 8'd0, 64'h40, a, "R8");
        // R7 / R4: register-amount select and amount width
        issue(4'd5, sel_lo(1), 8'd0, 64'h7F, a, "R7");
        issue(4'd5, sel_lo(0), 8'd0, 64'h7F, a, "R4");
        issue(4'd5, sel_lo(3), 8'd0, 64'h7F, a, "R7");
        issue(4'd14, sel_lo(1), 8'd0, 64'h7F, a, "R4");
        issue(4'd14, sel_lo(16), 8'd0, 64'h7F, a, "R7");
        issue(4'd3, '0, 8'd0, 64'hFFE1, a, "R4");
        issue(4'd12, '0, 8'd0, 64'h41, a, "R4");
        // R10: plus-32 forms
        issue(4'd9, '0, 8'd31, '0, 64'h1, "R10");
        issue(4'd10, '0, 8'd0, '0, a, "R10");
        issue(4'd11, sel_hi(0), 8'd4, '0, a, "R10");
        issue(4'd11, sel_hi(1), 8'd4, '0, a, "R10");
        issue(4'd11, sel_hi(1), 8'hE0, '0, a, "R10");
        // R13: doubleword shifts
        issue(4'd7, '0, 8'd5, '0, a, "R13");
        issue(4'd13, '0, 8'd0, 64'h3F, a, "R13");
        issue(4'd6, '0, 8'd12, '0, a, "R13");
        // R12: no-operation selector
        issue(4'd15, '0, 8'd1, 64'h1, a, "R12");
        idle(3);
        // R2: back-to-back then gaps
        issue(4'd1, '0, 8'd1, '0, a, "R2");
        idle(1);
        issue(4'd2, sel_hi(1), 8'd1, '0, a, "R2");
        idle(2);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins;
            ins = $urandom;
            if ($urandom % 4 != 0) begin
                ins[25:21] = 5'($urandom % 2);
                ins[10:6]  = 5'($urandom % 2);
            end
            issue(4'($urandom), ins, 8'($urandom), {$urandom, $urandom},
                  {$urandom, $urandom}, "R13");
            if ($urandom % 5 == 0) idle(1);
        end
        idle(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule